// File: doc/BRIEF.md
# Tag-Indexed Multicast Route Engine

This unit sits behind one input port of a mesh network-on-chip router. It looks at the flit waiting at the head of that port's input queue and decides which output links the flit must go to. Traffic is tracked by a small tag carried in every flit. All flits of one packet share the same tag on a link. A packet opens with one or more header flits and closes with a tail flit. A unicast packet has a single header. A multicast packet has one header per destination.

Each header flit is routed in dimension order toward its destination coordinates. The header requests that one output. When it is consumed, its direction is merged into a per-tag direction set. Body and tail flits read the set for their tag and request every output in it at once, which broadcasts the payload along every branch the headers opened. The engine holds a flit until every requested output has granted it, then pops the queue. It never asks again for an output that has already granted the current flit. When a tail flit is consumed, the set for its tag is erased so the tag can be reused.

The router position is fixed by parameters. Arbitration between input ports, re-tagging at the outputs and the queues themselves are left to neighbouring units.

Top module: `idtag_route_engine`

## Requirements
- R1: After reset no request is raised, `flitPop` is low and every tag's direction set is empty.
- R2: Flit fields. The type is in bits [15:13]: 1 is a header, 2 is a body, 3 is a tail, and any other value is undefined. The tag is in bits [12:10]. A header's destination x is in bits [3:2] and its destination y is in bits [1:0]. `hdrDirCode` gives the routing decision for a waiting header. The route goes east when the destination x is greater than the router's x and west when it is smaller. Only when the x values are equal does it go north (destination y greater) or south (destination y smaller). When both coordinates match it goes local. The codes are 0 local, 1 east, 2 north, 3 west and 4 south. When no header is waiting, `hdrDirCode` reads 7.
- R3: A waiting header requests only its own direction. That is bit `hdrDirCode` of `reqMask`, where bit 0 is local, bit 1 east, bit 2 north, bit 3 west and bit 4 south.
- R4: When a header is consumed, its direction is ORed into the direction set of its tag. Earlier headers of the same tag keep their bits.
- R5: A waiting body or tail flit requests the direction set of its tag, minus the outputs that have already granted this flit. When `flitValid` is low, `reqMask` is zero.
- R6: When a tail flit is consumed, the direction set of its tag becomes empty.
- R7: `flitPop` is high in the cycle in which the grants collected for the current flit, including this cycle's `grantIn`, cover its whole request set. The collected grants are then cleared for the next flit. A `grantIn` bit for an output that is not being requested has no effect.
- R8: A body or tail flit whose tag has an empty set is consumed in its first cycle without any request. So is a flit of undefined type, and it leaves every direction set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flitValid | input | 1 | Queue head holds a flit |
| flitData | input | 16 | Flit at the queue head |
| grantIn | input | 5 | Per-output grant for the current flit |
| reqMask | output | 5 | Per-output request (bit 0 local, 1 east, 2 north, 3 west, 4 south) |
| flitPop | output | 1 | Current flit consumed; advance the queue |
| hdrDirCode | output | 3 | Routing code of the waiting header, 7 when none |

## Verification
A wrong direction set shows up only later, in the request vector of the next body or tail flit with the same tag. The delay is the length of the remaining headers of that packet. The bench therefore compares `reqMask` in every cycle of every flit, not only at pops. A stale set after a tail shows up on the first reuse of that tag: a body is consumed at once with a request where none should be, or the other way round. A collected-grant register that is not cleared shows up on the very next flit as a missing request bit or an early `flitPop`.

// File: rtl/rte_pkg.sv
package rte_pkg;
  localparam int NUM_DIR = 5;
  localparam int TYPE_W  = 3;

  localparam logic [2:0] CODE_LOCAL = 3'd0;
  localparam logic [2:0] CODE_EAST  = 3'd1;
  localparam logic [2:0] CODE_NORTH = 3'd2;
  localparam logic [2:0] CODE_WEST  = 3'd3;
  localparam logic [2:0] CODE_SOUTH = 3'd4;
  localparam logic [2:0] CODE_NONE  = 3'd7;

  localparam logic [TYPE_W-1:0] KIND_HEAD = 3'd1;
  localparam logic [TYPE_W-1:0] KIND_BODY = 3'd2;
  localparam logic [TYPE_W-1:0] KIND_TAIL = 3'd3;

  typedef struct packed {
    logic writeHdr;
    logic clearEntry;
  } rteStrobe_t;
endpackage

// File: rtl/rte_datapath.sv
module rte_datapath
  import rte_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int CRD_W = 2,
  parameter int MY_X  = 1,
  parameter int MY_Y  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  rteStrobe_t         strobe,
  input  logic [ID_W-1:0]    flitId,
  input  logic [CRD_W-1:0]   destX,
  input  logic [CRD_W-1:0]   destY,
  output logic [NUM_DIR-1:0] lookupMask,
  output logic [NUM_DIR-1:0] hdrOneHot,
  output logic [2:0]         hdrCode
);
  localparam int NUM_ID = 1 << ID_W;
  localparam logic [CRD_W-1:0] HERE_X = CRD_W'(MY_X);
  localparam logic [CRD_W-1:0] HERE_Y = CRD_W'(MY_Y);

  logic [NUM_ID-1:0][NUM_DIR-1:0] dirTable;

  // dimension-ordered decision: x resolved before y
  always_comb begin
    if (destX > HERE_X)      hdrCode = CODE_EAST;
    else if (destX < HERE_X) hdrCode = CODE_WEST;
    else if (destY > HERE_Y) hdrCode = CODE_NORTH;
    else if (destY < HERE_Y) hdrCode = CODE_SOUTH;
    else                     hdrCode = CODE_LOCAL;
  end

  always_comb begin
    hdrOneHot = '0;
    for (int d = 0; d < NUM_DIR; d++) begin
      if (hdrCode == 3'(d)) hdrOneHot[d] = 1'b1;
    end
  end

  assign lookupMask = dirTable[flitId];

  for (genvar g = 0; g < NUM_ID; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirTable[g] <= '0;
      end else if (flitId == ID_W'(g)) begin
        if (strobe.clearEntry)    dirTable[g] <= '0;
        else if (strobe.writeHdr) dirTable[g] <= dirTable[g] | hdrOneHot;
      end
    end
  end

  a_r2_hdr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(hdrOneHot));

  a_r4_hdr_recorded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeHdr |=> ((dirTable[$past(flitId)] & $past(hdrOneHot)) != '0));

  a_r4_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeHdr |=> ((dirTable[$past(flitId)] & $past(lookupMask)) == $past(lookupMask)));

  a_r6_tail_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearEntry |=> (dirTable[$past(flitId)] == '0));
endmodule

// File: rtl/rte_control.sv
module rte_control
  import rte_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               flitValid,
  input  logic [TYPE_W-1:0]  flitKind,
  input  logic [NUM_DIR-1:0] hdrOneHot,
  input  logic [NUM_DIR-1:0] lookupMask,
  input  logic [NUM_DIR-1:0] grantIn,
  output logic [NUM_DIR-1:0] reqMask,
  output logic               flitPop,
  output rteStrobe_t         strobe
);
  logic [NUM_DIR-1:0] grantedQ;
  logic [NUM_DIR-1:0] needMask;
  logic [NUM_DIR-1:0] grantedNext;
  logic               isHead;
  logic               isPayload;

  assign isHead    = flitValid && (flitKind == KIND_HEAD);
  assign isPayload = flitValid && (flitKind == KIND_BODY || flitKind == KIND_TAIL);

  always_comb begin
    needMask = '0;
    if (isHead)         needMask = hdrOneHot;
    else if (isPayload) needMask = lookupMask;
  end

  assign reqMask     = needMask & ~grantedQ;
  assign grantedNext = grantedQ | (grantIn & reqMask);
  assign flitPop     = flitValid && ((grantedNext & needMask) == needMask);

  assign strobe.writeHdr   = flitPop && isHead;
  assign strobe.clearEntry = flitPop && flitValid && (flitKind == KIND_TAIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        grantedQ <= '0;
    else if (flitPop) grantedQ <= '0;
    else              grantedQ <= grantedNext;
  end

  a_r5_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !flitValid |-> (reqMask == '0 && !flitPop));

  a_r3_hdr_single_req: assert property (@(posedge clk) disable iff (!rstN)
    isHead |-> $onehot0(reqMask));

  a_r7_grants_cleared: assert property (@(posedge clk) disable iff (!rstN)
    flitPop |=> (grantedQ == '0));

  a_r7_no_repeat_req: assert property (@(posedge clk) disable iff (!rstN)
    (flitValid && !flitPop && $stable(flitKind) && (reqMask != '0)) |=> $stable(flitKind) ? ($countones(reqMask) <= $countones($past(reqMask))) : 1'b1);
endmodule

// File: rtl/idtag_route_engine.sv
module idtag_route_engine
  import rte_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int ID_W   = 3,
  parameter int CRD_W  = 2,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flitValid,
  input  logic [FLIT_W-1:0] flitData,
  input  logic [4:0]        grantIn,
  output logic [4:0]        reqMask,
  output logic              flitPop,
  output logic [2:0]        hdrDirCode
);
  localparam int KIND_LSB = FLIT_W - TYPE_W;
  localparam int ID_LSB   = KIND_LSB - ID_W;

  logic [TYPE_W-1:0]  flitKind;
  logic [ID_W-1:0]    flitId;
  logic [CRD_W-1:0]   destX;
  logic [CRD_W-1:0]   destY;
  logic [NUM_DIR-1:0] lookupMask;
  logic [NUM_DIR-1:0] hdrOneHot;
  logic [2:0]         hdrCode;
  rteStrobe_t         strobe;

  assign flitKind = flitData[FLIT_W-1:KIND_LSB];
  assign flitId   = flitData[KIND_LSB-1:ID_LSB];
  assign destX    = flitData[2*CRD_W-1:CRD_W];
  assign destY    = flitData[CRD_W-1:0];

  rte_datapath #(.ID_W(ID_W), .CRD_W(CRD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flitId(flitId),
    .destX(destX), .destY(destY), .lookupMask(lookupMask),
    .hdrOneHot(hdrOneHot), .hdrCode(hdrCode)
  );

  rte_control u_ctrl (
    .clk(clk), .rstN(rstN), .flitValid(flitValid), .flitKind(flitKind),
    .hdrOneHot(hdrOneHot), .lookupMask(lookupMask), .grantIn(grantIn),
    .reqMask(reqMask), .flitPop(flitPop), .strobe(strobe)
  );

  assign hdrDirCode = (flitValid && flitKind == KIND_HEAD) ? hdrCode : CODE_NONE;
endmodule

// File: tb/idtag_route_engine_tb.sv
module idtag_route_engine_tb;
  localparam int MY_X = 1;
  localparam int MY_Y = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flitValid = 1'b0;
  logic [15:0] flitData = '0;
  logic [4:0]  grantIn = '0;
  logic [4:0]  reqMask;
  logic        flitPop;
  logic [2:0]  hdrDirCode;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic [4:0] expTable [8];
  logic [4:0] expGranted;

  idtag_route_engine #(.MY_X(MY_X), .MY_Y(MY_Y)) u_dut (
    .clk(clk), .rstN(rstN), .flitValid(flitValid), .flitData(flitData),
    .grantIn(grantIn), .reqMask(reqMask), .flitPop(flitPop), .hdrDirCode(hdrDirCode)
  );

  always #2 clk = ~clk;

  function automatic logic [2:0] xyCode(input logic [1:0] dx, input logic [1:0] dy);
    if (dx > 2'(MY_X)) return 3'd1;
    if (dx < 2'(MY_X)) return 3'd3;
    if (dy > 2'(MY_Y)) return 3'd2;
    if (dy < 2'(MY_Y)) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [15:0] mkFlit(input logic [2:0] kind, input logic [2:0] id,
                                         input logic [1:0] dx, input logic [1:0] dy);
    return {kind, id, 6'd0, dx, dy};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  // present one flit until it is consumed; grantMode 0 random, 1 all, 2 none-then-all
  task automatic sendFlit(input logic [15:0] f, input int grantMode);
    logic [2:0] kind;
    logic [2:0] id;
    logic [4:0] need, expReq, grantNow;
    logic       expPop;
    logic [2:0] expCode;
    bit done = 0;
    int iter = 0;
    kind = f[15:13];
    id = f[12:10];
    while (!done) begin
      @(negedge clk);
      flitValid = 1'b1;
      flitData = f;
      case (grantMode)
        0: grantIn = 5'($urandom);
        1: grantIn = 5'h1f;
        default: grantIn = (iter == 0) ? 5'h00 : 5'h1f;
      endcase
      #1;
      expCode = (kind == 3'd1) ? xyCode(f[3:2], f[1:0]) : 3'd7;
      if (kind == 3'd1) need = 5'(1) << expCode;
      else if (kind == 3'd2 || kind == 3'd3) need = expTable[id];
      else need = '0;
      expReq = need & ~expGranted;
      grantNow = grantIn & expReq;
      expPop = (((expGranted | grantNow) & need) == need);
      check("R2 hdrDirCode", hdrDirCode, expCode);
      if (kind == 3'd1) check("R3 header reqMask", reqMask, expReq);
      else check("R4 R5 R8 payload reqMask", reqMask, expReq);
      check("R7 flitPop", flitPop, expPop);
      @(posedge clk);
      if (expPop) begin
        expGranted = '0;
        if (kind == 3'd1) expTable[id] = expTable[id] | need;
        if (kind == 3'd3) expTable[id] = '0;
        done = 1;
      end else begin
        expGranted = expGranted | grantNow;
      end
      iter++;
      if (iter > 200) begin
        mismatched++;
        $display("FAIL R7 flit never consumed");
        done = 1;
      end
    end
    @(negedge clk);
    flitValid = 1'b0;
    grantIn = '0;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    flitValid = 1'b0;
    grantIn = 5'h1f;
    #1;
    check("R5 idle reqMask", reqMask, 0);
    check("R5 idle flitPop", flitPop, 0);
    check("R2 idle hdrDirCode", hdrDirCode, 7);
    grantIn = '0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) expTable[i] = '0;
    expGranted = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset reqMask", reqMask, 0);
    check("R1 reset flitPop", flitPop, 0);
    rstN = 1'b1;

    // R1: empty sets after reset, so a body drops at once with no request
    @(negedge clk);
    flitValid = 1'b1;
    flitData = mkFlit(3'd2, 3'd5, 2'd0, 2'd0);
    grantIn = '0;
    #1;
    check("R1 R8 body on empty tag reqMask", reqMask, 0);
    check("R1 R8 body on empty tag flitPop", flitPop, 1);
    @(posedge clk);
    idleCheck();

    // R2: each direction from a header
    sendFlit(mkFlit(3'd1, 3'd0, 2'd3, 2'd0), 1);
    sendFlit(mkFlit(3'd1, 3'd0, 2'd0, 2'd3), 1);
    sendFlit(mkFlit(3'd1, 3'd0, 2'd1, 2'd3), 1);
    sendFlit(mkFlit(3'd1, 3'd0, 2'd1, 2'd0), 1);
    sendFlit(mkFlit(3'd1, 3'd0, 2'd1, 2'd2), 1);
    // R4: all five bits merged, then payload broadcast with stalled grants
    sendFlit(mkFlit(3'd2, 3'd0, 2'd0, 2'd0), 2);
    sendFlit(mkFlit(3'd2, 3'd0, 2'd0, 2'd0), 0);
    sendFlit(mkFlit(3'd3, 3'd0, 2'd0, 2'd0), 0);
    // R6: tag reuse after tail drops at once
    @(negedge clk);
    flitValid = 1'b1;
    flitData = mkFlit(3'd2, 3'd0, 2'd0, 2'd0);
    grantIn = '0;
    #1;
    check("R6 cleared tag reqMask", reqMask, 0);
    check("R6 cleared tag flitPop", flitPop, 1);
    @(posedge clk);
    idleCheck();

    // R8: undefined types leave the sets alone
    sendFlit(mkFlit(3'd1, 3'd4, 2'd3, 2'd3), 1);
    sendFlit(mkFlit(3'd6, 3'd4, 2'd0, 2'd0), 0);
    sendFlit(mkFlit(3'd0, 3'd4, 2'd0, 2'd0), 0);
    sendFlit(mkFlit(3'd2, 3'd4, 2'd0, 2'd0), 2);
    sendFlit(mkFlit(3'd3, 3'd4, 2'd0, 2'd0), 0);

    // two interleaved multicast packets
    sendFlit(mkFlit(3'd1, 3'd1, 2'd3, 2'd1), 0);
    sendFlit(mkFlit(3'd1, 3'd2, 2'd0, 2'd1), 0);
    sendFlit(mkFlit(3'd1, 3'd1, 2'd1, 2'd0), 0);
    sendFlit(mkFlit(3'd2, 3'd2, 2'd0, 2'd0), 0);
    sendFlit(mkFlit(3'd2, 3'd1, 2'd0, 2'd0), 0);
    sendFlit(mkFlit(3'd3, 3'd2, 2'd0, 2'd0), 0);
    sendFlit(mkFlit(3'd3, 3'd1, 2'd0, 2'd0), 0);

    // random packets
    for (int p = 0; p < 60; p++) begin
      logic [2:0] id;
      int nh, nb;
      id = 3'($urandom);
      nh = 1 + int'($urandom % 4);
      nb = int'($urandom % 6);
      for (int h = 0; h < nh; h++)
        sendFlit(mkFlit(3'd1, id, 2'($urandom), 2'($urandom)), 0);
      for (int b = 0; b < nb; b++) sendFlit(mkFlit(3'd2, id, 2'($urandom), 2'($urandom)), 0);
      sendFlit(mkFlit(3'd3, id, 2'($urandom), 2'($urandom)), 0);
      if (($urandom % 4) == 0) idleCheck();
    end

    finishRun();
  end
endmodule